// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when an asynchronous page-mode DRAM array has to be refreshed, and it runs the power-up sequence the array needs before first use. After reset it keeps quiet for a settle interval of at least 200 us. It then asks for a burst of warm-up refresh cycles, counting the acknowledges, and only after the last one does it raise a ready flag that lets host traffic through. From then on it makes periodic refresh requests, one for each slice of the retention period, so that 4096 refresh cycles cover the whole array every 64 ms.

Requests travel over a level request / pulse acknowledge handshake toward the DRAM access controller. The controller performs the CAS-before-RAS cycle itself, and the DRAM's own row counter picks the row, so the block supplies no address. During steady operation a pending-refresh count rises on every interval tick and falls on every acknowledge. The request stays high while the count is nonzero, so refreshes that are held off by a long page burst are made up afterwards. If the count reaches its limit, a sticky overflow flag reports that the retention guarantee may have been broken.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, refresh_req, ready and refresh_overflow are all 0. Reset is synchronous and active high.
- R2: After reset is released, refresh_req stays 0 for exactly PAUSE_CYC = ceil(PAUSE_NS*1000 / CLK_PERIOD_PS) clock edges. It reads 1 after the PAUSE_CYC-th edge. Acknowledges during the pause have no effect.
- R3: After the pause, refresh_req stays at 1 without a break until WARMUP_REFRESHES acknowledges (refresh_ack high on a clock edge) have been taken.
- R4: ready is 0 until the edge that takes the final warm-up acknowledge. From that edge on it is 1 and stays 1 until reset.
- R5: Once ready is 1, an interval tick occurs every INTERVAL_CYC = floor(floor(RETENTION_US*1000 / REFRESH_ROWS) * 1000 / CLK_PERIOD_PS) edges. The first tick is counted on the INTERVAL_CYC-th edge after the edge that set ready.
- R6: In steady operation, each tick adds one to the pending count and each acknowledge taken while the count is nonzero removes one. A tick and an acknowledge on the same edge cancel. An acknowledge at count 0 is ignored. refresh_req is 1 exactly while the count is nonzero.
- R7: The pending count never exceeds DEBT_MAX; extra ticks at the limit are dropped. refresh_overflow becomes 1 on the edge where the count reaches DEBT_MAX and stays 1 until reset.
- R8: A reset in any phase restarts the full sequence: ready, refresh_overflow and refresh_req return to 0, and a new pause begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_ack | input | 1 | One-cycle pulse from the access controller, one per completed refresh |
| refresh_req | output | 1 | Refresh wanted (level) |
| ready | output | 1 | Initialization complete; host access allowed |
| refresh_overflow | output | 1 | Sticky: pending refresh count reached its limit |

## Verification
The hardest state to reach from the ports is saturation of the pending count. It requires the controller to withhold acknowledges for more than DEBT_MAX whole intervals after the warm-up has finished. The bench shortens the pause and the retention period through parameters, starves the block of acknowledges for several intervals, and then drains the count. During the drain it checks that overflow stays set, that ticks at the limit were dropped, and that surplus acknowledges at zero do not leave a negative debt that would swallow the next tick.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic [1:0] {
        PH_PAUSE = 2'd0,
        PH_WARM  = 2'd1,
        PH_RUN   = 2'd2
    } drs_phase_e;

    // one edge's worth of events seen by the pending counter
    typedef struct packed {
        logic tick;
        logic ack;
    } debt_evt_t;

    // pause rounded up so the settle time is never shortened
    function automatic int pause_cycles(input int pause_ns, input int clk_ps);
        longint num;
        num = longint'(pause_ns) * 64'd1000;
        return int'((num + longint'(clk_ps) - 1) / longint'(clk_ps));
    endfunction

    // interval rounded down so refresh is never late
    function automatic int interval_cycles(input int ret_us, input int rows, input int clk_ps);
        longint slot_ns;
        slot_ns = (longint'(ret_us) * 64'd1000) / longint'(rows);
        return int'((slot_ns * 64'd1000) / longint'(clk_ps));
    endfunction

endpackage

// File: rtl/drs_init_seq.sv
module drs_init_seq
    import drs_pkg::*;
#(
    parameter int PAUSE_CYC = 50000,
    parameter int WARMUP_N  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ack,
    output drs_phase_e phase,
    output logic       ready
);
    localparam int TW = $clog2(PAUSE_CYC + 1);
    localparam int WW = $clog2(WARMUP_N + 1);
    localparam logic [TW-1:0] T_LAST = TW'(PAUSE_CYC - 1);
    localparam logic [WW-1:0] W_LAST = WW'(WARMUP_N - 1);

    logic [TW-1:0] timer;
    logic [WW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_PAUSE;
            timer <= '0;
            wcnt  <= '0;
            ready <= 1'b0;
        end else begin
            case (phase)
                PH_PAUSE: begin
                    if (timer == T_LAST) begin
                        phase <= PH_WARM;
                        timer <= '0;
                    end else begin
                        timer <= timer + 1'b1;
                    end
                end
                PH_WARM: begin
                    if (ack) begin
                        if (wcnt == W_LAST) begin
                            phase <= PH_RUN;
                            ready <= 1'b1;
                        end else begin
                            wcnt <= wcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R4: once raised, ready holds until reset
    p_ready_hold_r4: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    // R2/R3: no ready outside steady operation
    p_not_ready_early_r2: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_RUN) |-> !ready);

    // R8: steady operation is left only through reset
    p_run_final_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RUN) |=> (phase == PH_RUN));

    // R3: the pause is never re-entered without reset
    p_no_back_to_pause_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_WARM) |=> (phase != PH_PAUSE));

endmodule

// File: rtl/drs_tick_gen.sv
module drs_tick_gen #(
    parameter int INTERVAL_CYC = 3906
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam logic [IW-1:0] I_LAST = IW'(INTERVAL_CYC - 1);

    logic [IW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == I_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == I_LAST);

    // R5: ticks only in steady operation
    p_tick_only_run_r5: assert property (@(posedge clk) disable iff (rst)
        tick |-> en);

    // R5: two ticks are never adjacent
    p_tick_spaced_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/drs_debt_ctr.sv
module drs_debt_ctr
    import drs_pkg::*;
#(
    parameter int DEBT_MAX = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  debt_evt_t evt,
    output logic      pending_nz,
    output logic      overflow
);
    localparam int DW = $clog2(DEBT_MAX + 1);
    localparam logic [DW-1:0] D_MAX = DW'(DEBT_MAX);

    logic [DW-1:0] pending;
    logic [DW-1:0] nxt;
    logic          dec;

    always_comb begin
        dec = evt.ack && (pending != '0);
        nxt = pending;
        case ({evt.tick, dec})
            2'b10:   nxt = (pending == D_MAX) ? D_MAX : pending + 1'b1;
            2'b01:   nxt = pending - 1'b1;
            default: nxt = pending;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= '0;
            overflow <= 1'b0;
        end else begin
            pending  <= nxt;
            overflow <= overflow | (nxt == D_MAX);
        end
    end

    assign pending_nz = (pending != '0);

    // R7: bounded count
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        pending <= D_MAX);

    // R7: sticky error flag
    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R6: an acknowledge alone retires one refresh
    p_ack_retires_r6: assert property (@(posedge clk) disable iff (rst)
        (evt.ack && !evt.tick && pending != '0) |=> (pending == $past(pending) - 1'b1));

    // R6: an acknowledge at zero leaves the count at zero
    p_ack_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!evt.tick && pending == '0) |=> (pending == '0));

    // R6: a tick below the limit adds one
    p_tick_adds_r6: assert property (@(posedge clk) disable iff (rst)
        (evt.tick && !evt.ack && pending != D_MAX) |=> (pending == $past(pending) + 1'b1));

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import drs_pkg::*;
#(
    parameter int CLK_PERIOD_PS    = 4000,
    parameter int PAUSE_NS         = 200000,
    parameter int WARMUP_REFRESHES = 8,
    parameter int RETENTION_US     = 64000,
    parameter int REFRESH_ROWS     = 4096,
    parameter int DEBT_MAX         = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic refresh_ack,
    output logic refresh_req,
    output logic ready,
    output logic refresh_overflow
);
    localparam int PAUSE_CYC    = pause_cycles(PAUSE_NS, CLK_PERIOD_PS);
    localparam int INTERVAL_CYC = interval_cycles(RETENTION_US, REFRESH_ROWS, CLK_PERIOD_PS);

    drs_phase_e phase;
    logic       tick;
    logic       pending_nz;
    logic       in_run;
    logic       in_warm;
    debt_evt_t  evt;

    assign in_run  = (phase == PH_RUN);
    assign in_warm = (phase == PH_WARM);

    drs_init_seq #(
        .PAUSE_CYC (PAUSE_CYC),
        .WARMUP_N  (WARMUP_REFRESHES)
    ) u_init (
        .clk   (clk),
        .rst   (rst),
        .ack   (refresh_ack && in_warm),
        .phase (phase),
        .ready (ready)
    );

    drs_tick_gen #(
        .INTERVAL_CYC (INTERVAL_CYC)
    ) u_tick (
        .clk  (clk),
        .rst  (rst),
        .en   (in_run),
        .tick (tick)
    );

    assign evt.tick = tick;
    assign evt.ack  = refresh_ack && in_run;

    drs_debt_ctr #(
        .DEBT_MAX (DEBT_MAX)
    ) u_debt (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .pending_nz (pending_nz),
        .overflow   (refresh_overflow)
    );

    assign refresh_req = in_warm || (in_run && pending_nz);

    // R2: silent during the pause
    p_quiet_pause_r2: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_PAUSE) |-> (!refresh_req && !ready));

    // R3: request held through the warm-up burst
    p_req_warm_r3: assert property (@(posedge clk) disable iff (rst)
        (!ready && refresh_req) |=> (refresh_req || ready));

    // R7: no overflow before steady operation
    p_ovf_only_run_r7: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !refresh_overflow);

    // R1: outputs cleared after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!refresh_req && !ready && !refresh_overflow));

    initial begin
        assert (PAUSE_CYC >= 1) else $error("pause too short");
        assert (INTERVAL_CYC >= 2) else $error("interval too short");
        assert (WARMUP_REFRESHES >= 1) else $error("warm-up count");
        assert (DEBT_MAX >= 1) else $error("debt limit");
    end

endmodule

// File: tb/dram_refresh_sched_test.sv
`timescale 1ns/1ps
module dram_refresh_sched_test;

    localparam int PER_PS   = 4000;
    localparam int P_NS     = 4000;
    localparam int WARM     = 8;
    localparam int RET_US   = 1024;
    localparam int ROWS     = 4096;
    localparam int DMAX     = 5;

    // expected figures straight from the requirement formulas
    localparam longint PAUSE_E = (longint'(P_NS) * 1000 + PER_PS - 1) / PER_PS;
    localparam longint INT_E   = ((longint'(RET_US) * 1000) / ROWS) * 1000 / PER_PS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic refresh_ack = 1'b0;
    logic refresh_req, ready, refresh_overflow;

    always #2 clk = ~clk;

    dram_refresh_sched #(
        .CLK_PERIOD_PS    (PER_PS),
        .PAUSE_NS         (P_NS),
        .WARMUP_REFRESHES (WARM),
        .RETENTION_US     (RET_US),
        .REFRESH_ROWS     (ROWS),
        .DEBT_MAX         (DMAX)
    ) uut (
        .clk              (clk),
        .rst              (rst),
        .refresh_ack      (refresh_ack),
        .refresh_req      (refresh_req),
        .ready            (ready),
        .refresh_overflow (refresh_overflow)
    );

    int checks = 0;
    int fails  = 0;
    longint cyc = 0;

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    // behavioural reference model
    int  m_phase = 0;     // 0 pause, 1 warm-up, 2 steady
    longint m_t = 0;
    int  m_w = 0;
    longint m_it = 0;
    int  m_debt = 0;
    bit  m_ready = 0;
    bit  m_ovf = 0;
    bit  m_rst = 1;

    always @(posedge clk) begin
        cyc++;
        m_rst = rst;
        if (rst) begin
            m_phase = 0; m_t = 0; m_w = 0; m_it = 0; m_debt = 0;
            m_ready = 0; m_ovf = 0;
        end else if (m_phase == 0) begin
            m_t++;
            if (m_t == PAUSE_E) m_phase = 1;
        end else if (m_phase == 1) begin
            if (refresh_ack) begin
                m_w++;
                if (m_w == WARM) begin
                    m_phase = 2; m_ready = 1; m_it = 0; m_debt = 0;
                end
            end
        end else begin
            int d;
            bit tk;
            m_it++;
            tk = (m_it == INT_E);
            if (tk) m_it = 0;
            d = m_debt;
            if (tk) d++;
            if (refresh_ack && m_debt > 0) d--;
            if (d > DMAX) d = DMAX;
            if (d == DMAX) m_ovf = 1;
            m_debt = d;
        end
    end

    // compare every cycle, away from the active edge
    bit compare_on = 0;
    always @(negedge clk) begin
        if (compare_on) begin
            string t;
            bit exp_req;
            exp_req = (m_phase == 1) || (m_phase == 2 && m_debt > 0);
            t = m_rst ? "R1" : (m_phase == 0) ? "R2" : (m_phase == 1) ? "R3" : "R6";
            chk(t, int'(refresh_req), int'(exp_req), "refresh_req vs model");
            chk(m_rst ? "R1" : "R4", int'(ready), int'(m_ready), "ready vs model");
            chk(m_rst ? "R1" : "R7", int'(refresh_overflow), int'(m_ovf), "overflow vs model");
        end
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 200000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic ack_pulse();
        @(negedge clk) refresh_ack = 1'b1;
        @(negedge clk) refresh_ack = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // steady operation with an attentive controller; measures tick spacing
    task automatic serve(input int n, input bit measure);
        longint last_rise = -1;
        bit prev = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (measure && refresh_req && !prev) begin
                if (last_rise >= 0)
                    chk("R5", int'(cyc - last_rise), int'(INT_E), "cycles between requests");
                last_rise = cyc;
            end
            prev = refresh_req;
            refresh_ack = refresh_req && !refresh_ack;
        end
        @(negedge clk) refresh_ack = 1'b0;
    endtask

    task automatic pause_and_warm();
        int n = 0;
        // R2: count edges until the request appears; acks in between are ignored
        do begin
            @(negedge clk);
            n++;
            refresh_ack = (n % 97 == 5) && (n < PAUSE_E - 2);
        end while (!refresh_req && n < PAUSE_E + 10);
        chk("R2", n, int'(PAUSE_E), "edges from reset release to first request");
        refresh_ack = 1'b0;
        // warm-up burst, with gaps between acknowledges
        for (int k = 1; k <= WARM; k++) begin
            idle(k % 3);
            ack_pulse();
            if (k == WARM - 1) begin
                chk("R4", int'(ready), 0, "ready before final warm-up ack");
                chk("R3", int'(refresh_req), 1, "request during warm-up");
            end
        end
        chk("R4", int'(ready), 1, "ready after final warm-up ack");
    endtask

    initial begin
        compare_on = 1'b1;
        idle(4);
        chk("R1", int'(refresh_req), 0, "req in reset");
        chk("R1", int'(ready), 0, "ready in reset");
        rst = 1'b0;
        pause_and_warm();

        // regular service: spacing of ticks
        serve(int'(INT_E) * 6, 1'b1);
        chk("R6", int'(refresh_req), 0, "no backlog under prompt service");

        // starvation past the limit
        idle(int'(INT_E) * (DMAX + 3));
        chk("R7", int'(refresh_overflow), 1, "overflow after starvation");
        chk("R6", int'(refresh_req), 1, "request held while backlog");

        // drain, then surplus acknowledges at zero
        serve(DMAX * 4, 1'b0);
        chk("R7", int'(refresh_overflow), 1, "overflow sticky after drain");
        for (int k = 0; k < 3; k++) ack_pulse();
        serve(int'(INT_E) * 3, 1'b0);

        // reset in the middle of steady operation
        @(negedge clk) rst = 1'b1;
        idle(2);
        rst = 1'b0;
        @(negedge clk);
        chk("R8", int'(ready), 0, "ready after mid-run reset");
        chk("R8", int'(refresh_overflow), 0, "overflow after mid-run reset");
        chk("R8", int'(refresh_req), 0, "request after mid-run reset");
        idle(int'(PAUSE_E) - 3);
        chk("R8", int'(refresh_req), 0, "new pause still running");
        idle(3);
        chk("R8", int'(refresh_req), 1, "warm-up request after new pause");

        compare_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule